// File: doc/BRIEF.md
# Nine-Bit Serial Port with Receive DMA Steering

This block is an asynchronous serial transmitter and receiver for 8-bit or 9-bit characters. Each frame is one low start bit, the data bits least significant first, an optional ninth bit, and one high stop bit. The bit time is a fixed number of clock cycles set by a parameter. Software reaches the block through a small register bus. Writing the data register starts a transmission. Reading it returns the last received byte and releases the receive-full flag.

The ninth bit moves together with its byte in both directions. On transmit, the stored outgoing ninth bit is copied into the shift register in the same cycle as the byte. On receive, the captured ninth bit is written in the same cycle as the byte. The receive-full event has exactly one destination. When receive DMA is enabled it raises a DMA request, and the CPU interrupt stays quiet. When receive DMA is disabled it raises the CPU interrupt, and no DMA request is made. Overrun and missing-stop-bit errors are latched and can be routed to a separate error interrupt.

Top module: `uart9_dma_steer`

## Requirements
- R1: `txd` idles high. A frame is sent as a low start bit, then the data bits LSB first, then bit 8 only when the mode register (address 2, bit 0) is 1, then a high stop bit. Each bit lasts CLKS_PER_BIT cycles.
- R2: In 9-bit mode, the outgoing ninth bit is control bit 6, sampled in the cycle the data register (address 0) is written. Changing control bit 6 afterwards does not alter the frame in flight.
- R3: In 9-bit mode, a received character's low 8 bits are read at address 0 and its bit 8 is read as control bit 7.
- R4: In 8-bit mode, control bit 7 reads as a copy of bit 7 of the received byte.
- R5: Control bit 7 and the receive data register are updated in the same cycle that the receive-full flag (status bit 1) sets.
- R6: A reset leaves control bits 7 and 6 unchanged.
- R7: Reset clears control bits 5 to 0, the mode bit, and the status flags. After reset the status register (address 2) reads 0: bit 0 mode, bit 1 full, bit 2 overrun, bit 3 framing, bit 4 transmitter busy.
- R8: With control bit 5 (receive DMA enable) set, a full receiver raises `dma_req` and keeps `rx_irq` low.
- R9: With control bit 5 clear, a full receiver raises `rx_irq` and keeps `dma_req` low.
- R10: The receive-full flag clears when address 0 is read or when `dma_ack` is pulsed.
- R11: A character that completes while the receiver is full sets the overrun flag and leaves the held byte unchanged. With control bit 3 set, `err_irq` is raised. Reading the status register clears the flag.
- R12: A low stop bit sets the framing flag. `err_irq` is raised only when control bit 1 is set. Reading the status register clears the flag.
- R13: Writes to control bit 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects) |
| bus_addr | input | 2 | Register address: 0 data, 1 control, 2 mode/status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| rx_irq | output | 1 | Receive-full CPU interrupt |
| err_irq | output | 1 | Error interrupt (overrun, framing) |
| dma_req | output | 1 | Receive DMA request |
| dma_ack | input | 1 | DMA acknowledge, clears receive-full |

## Verification
The hardest case to reach is the one where the ninth bit must stay bound to its byte while software changes it. The stimulus writes the data register and rewrites the outgoing ninth bit one cycle later, while a concurrent serial decoder captures the frame already in flight. The reset-survival case is also hard to reach. The stimulus first receives a character to load a known captured ninth bit, then pulses reset with no frame active and reads both bits back. Overrun is reached by sending two characters back to back without a read.

// File: rtl/uart9_pkg.sv
package uart9_pkg;
  localparam int DATA_W = 8;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_MODE = 2'd2;

  localparam int CB_DMA_RX = 5;
  localparam int CB_OVR_IE = 3;
  localparam int CB_FRM_IE = 1;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_t;
endpackage

// File: rtl/uart9_rst_sync.sv
module uart9_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/uart9_tx.sv
module uart9_tx #(
  parameter int CLKS_PER_BIT = 8,
  parameter int DATA_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              nine,
  input  logic [DATA_W:0]   word,
  output logic              txd,
  output logic              busy
);
  localparam int FRAME_MAX = DATA_W + 3;
  localparam int CW        = $clog2(CLKS_PER_BIT);
  localparam int LW        = $clog2(FRAME_MAX + 1);

  logic [FRAME_MAX-1:0] sh_q, sh_d;
  logic [CW-1:0]        cnt_q, cnt_d;
  logic [LW-1:0]        left_q, left_d;
  logic                 busy_q, busy_d;

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    left_d = left_q;
    busy_d = busy_q;
    if (!busy_q) begin
      if (load) begin
        busy_d = 1'b1;
        cnt_d  = '0;
        sh_d   = nine ? {1'b1, word, 1'b0}
                      : {2'b11, word[DATA_W-1:0], 1'b0};
        left_d = nine ? LW'(FRAME_MAX) : LW'(FRAME_MAX - 1);
      end
    end else if (cnt_q == CW'(CLKS_PER_BIT - 1)) begin
      cnt_d  = '0;
      sh_d   = {1'b1, sh_q[FRAME_MAX-1:1]};
      left_d = left_q - LW'(1);
      if (left_q == LW'(1)) busy_d = 1'b0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      left_q <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      left_q <= left_d;
    end
  end

  always_ff @(posedge clk) begin
    sh_q <= sh_d;
  end

  assign txd  = busy_q ? sh_q[0] : 1'b1;
  assign busy = busy_q;
endmodule

// File: rtl/uart9_rx.sv
module uart9_rx
  import uart9_pkg::*;
#(
  parameter int CLKS_PER_BIT = 8,
  parameter int DATA_W       = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rxd,
  input  logic            nine,
  output logic            done,
  output logic [DATA_W:0] word,
  output logic            stop_ok
);
  localparam int CW   = $clog2(CLKS_PER_BIT);
  localparam int IW   = $clog2(DATA_W + 1);
  localparam int HALF = CLKS_PER_BIT / 2;

  rx_state_t       st_q, st_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [IW-1:0]   idx_q, idx_d;
  logic [IW-1:0]   last_idx;
  logic [DATA_W:0] sh_q, sh_d;
  logic            done_q, done_d;
  logic            stop_q, stop_d;
  logic            rx_m, rx_s, rx_p;

  assign last_idx = nine ? IW'(DATA_W) : IW'(DATA_W - 1);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q + CW'(1);
    idx_d  = idx_q;
    sh_d   = sh_q;
    done_d = 1'b0;
    stop_d = stop_q;
    case (st_q)
      RX_IDLE: begin
        cnt_d = '0;
        if (!rx_s && rx_p) st_d = RX_START;
      end
      RX_START: begin
        if (cnt_q == CW'(HALF - 1)) begin
          cnt_d = '0;
          idx_d = '0;
          st_d  = rx_s ? RX_IDLE : RX_DATA;
        end
      end
      RX_DATA: begin
        if (cnt_q == CW'(CLKS_PER_BIT - 1)) begin
          cnt_d       = '0;
          sh_d[idx_q] = rx_s;
          if (idx_q == last_idx) st_d = RX_STOP;
          else                   idx_d = idx_q + IW'(1);
        end
      end
      default: begin
        if (cnt_q == CW'(CLKS_PER_BIT - 1)) begin
          cnt_d  = '0;
          done_d = 1'b1;
          stop_d = rx_s;
          st_d   = RX_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m   <= 1'b1;
      rx_s   <= 1'b1;
      rx_p   <= 1'b1;
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      done_q <= 1'b0;
      stop_q <= 1'b1;
    end else begin
      rx_m   <= rxd;
      rx_s   <= rx_m;
      rx_p   <= rx_s;
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      done_q <= done_d;
      stop_q <= stop_d;
    end
  end

  always_ff @(posedge clk) begin
    sh_q <= sh_d;
  end

  assign done    = done_q;
  assign word    = sh_q;
  assign stop_ok = stop_q;
endmodule

// File: rtl/uart9_dma_steer.sv
module uart9_dma_steer
  import uart9_pkg::*;
#(
  parameter int CLKS_PER_BIT = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       rxd,
  output logic       txd,
  output logic       rx_irq,
  output logic       err_irq,
  output logic       dma_req,
  input  logic       dma_ack
);
  logic            srst_n;
  logic            tx_busy, tx_load;
  logic            rx_done, rx_stop_ok, rx_load;
  logic [DATA_W:0] rx_word;

  logic [5:0]        ctrl_q, ctrl_d;
  logic              nine_q, nine_d;
  logic              full_q, full_d;
  logic              ovr_q, ovr_d;
  logic              frm_q, frm_d;
  logic              t8_q, r8_q;
  logic [DATA_W-1:0] rxbuf_q;

  logic wr_data, wr_ctrl, wr_mode, rd_data, rd_stat, rel_full;

  uart9_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  assign wr_data  = bus_wr && (bus_addr == ADDR_DATA);
  assign wr_ctrl  = bus_wr && (bus_addr == ADDR_CTRL);
  assign wr_mode  = bus_wr && (bus_addr == ADDR_MODE);
  assign rd_data  = bus_rd && (bus_addr == ADDR_DATA);
  assign rd_stat  = bus_rd && (bus_addr == ADDR_MODE);
  assign rel_full = rd_data || dma_ack;
  assign tx_load  = wr_data && !tx_busy;
  assign rx_load  = rx_done && !(full_q && !rel_full);

  uart9_tx #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_W(DATA_W)) u_tx (
    .clk   (clk),
    .rst_n (srst_n),
    .load  (tx_load),
    .nine  (nine_q),
    .word  ({t8_q, bus_wdata}),
    .txd   (txd),
    .busy  (tx_busy)
  );

  uart9_rx #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_W(DATA_W)) u_rx (
    .clk     (clk),
    .rst_n   (srst_n),
    .rxd     (rxd),
    .nine    (nine_q),
    .done    (rx_done),
    .word    (rx_word),
    .stop_ok (rx_stop_ok)
  );

  always_comb begin
    ctrl_d = ctrl_q;
    nine_d = nine_q;
    full_d = full_q;
    ovr_d  = ovr_q;
    frm_d  = frm_q;
    if (wr_ctrl) ctrl_d = bus_wdata[5:0];
    if (wr_mode) nine_d = bus_wdata[0];
    if (rd_stat) begin
      ovr_d = 1'b0;
      frm_d = 1'b0;
    end
    if (rel_full) full_d = 1'b0;
    if (rx_done) begin
      if (full_d) ovr_d  = 1'b1;
      else        full_d = 1'b1;
      if (!rx_stop_ok) frm_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ctrl_q <= '0;
      nine_q <= 1'b0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      frm_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      nine_q <= nine_d;
      full_q <= full_d;
      ovr_q  <= ovr_d;
      frm_q  <= frm_d;
    end
  end

  // Ninth-bit holders and receive buffer carry no reset term.
  always_ff @(posedge clk) begin
    if (wr_ctrl) t8_q <= bus_wdata[6];
  end

  always_ff @(posedge clk) begin
    if (rx_load) begin
      r8_q    <= nine_q ? rx_word[DATA_W] : rx_word[DATA_W-1];
      rxbuf_q <= rx_word[DATA_W-1:0];
    end
  end

  always_comb begin
    case (bus_addr)
      ADDR_DATA: bus_rdata = rxbuf_q;
      ADDR_CTRL: bus_rdata = {r8_q, t8_q, ctrl_q};
      ADDR_MODE: bus_rdata = {3'b000, tx_busy, frm_q, ovr_q, full_q, nine_q};
      default:   bus_rdata = '0;
    endcase
  end

  assign rx_irq  = full_q && !ctrl_q[CB_DMA_RX];
  assign dma_req = full_q &&  ctrl_q[CB_DMA_RX];
  assign err_irq = (ovr_q && ctrl_q[CB_OVR_IE]) || (frm_q && ctrl_q[CB_FRM_IE]);
endmodule

// File: rtl/uart9_dma_steer_chk.sv
module uart9_dma_steer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       srst_n,
  input logic       txd,
  input logic       tx_busy,
  input logic       rx_irq,
  input logic       dma_req,
  input logic       dma_ack,
  input logic       rd_data,
  input logic       rx_done,
  input logic       rx_stop_ok,
  input logic       full_q,
  input logic       ovr_q,
  input logic       frm_q,
  input logic [5:0] ctrl_q
);
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n || !srst_n)
    !tx_busy |-> txd);

  p_one_target_r8: assert property (@(posedge clk) disable iff (!rst_n || !srst_n)
    1'b1 |-> !(rx_irq && dma_req));

  p_dma_masks_cpu_r8: assert property (@(posedge clk) disable iff (!rst_n || !srst_n)
    ctrl_q[5] |-> !rx_irq);

  p_cpu_no_dma_r9: assert property (@(posedge clk) disable iff (!rst_n || !srst_n)
    !ctrl_q[5] |-> !dma_req);

  p_load_sets_full_r5: assert property (@(posedge clk) disable iff (!rst_n || !srst_n)
    (rx_done && !full_q) |=> full_q);

  p_ack_clears_r10: assert property (@(posedge clk) disable iff (!rst_n || !srst_n)
    (full_q && dma_ack && !rx_done) |=> !full_q);

  p_overrun_r11: assert property (@(posedge clk) disable iff (!rst_n || !srst_n)
    (rx_done && full_q && !dma_ack && !rd_data) |=> (ovr_q && full_q));

  p_framing_r12: assert property (@(posedge clk) disable iff (!rst_n || !srst_n)
    (rx_done && !rx_stop_ok) |=> frm_q);
endmodule

bind uart9_dma_steer uart9_dma_steer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .srst_n     (srst_n),
  .txd        (txd),
  .tx_busy    (tx_busy),
  .rx_irq     (rx_irq),
  .dma_req    (dma_req),
  .dma_ack    (dma_ack),
  .rd_data    (rd_data),
  .rx_done    (rx_done),
  .rx_stop_ok (rx_stop_ok),
  .full_q     (full_q),
  .ovr_q      (ovr_q),
  .frm_q      (frm_q),
  .ctrl_q     (ctrl_q)
);

// File: tb/tb_uart9_dma_steer.sv
module tb_uart9_dma_steer;
  localparam int CPB = 8;

  logic       clk;
  logic       rst_n;
  logic       bus_wr, bus_rd;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       rxd, txd, rx_irq, err_irq, dma_req, dma_ack;

  int checks = 0;
  int errors = 0;

  logic [7:0] rv;
  logic [8:0] got;
  logic       gstp;
  logic [7:0] b8;
  logic [8:0] v9;
  logic       r8_exp;

  uart9_dma_steer #(.CLKS_PER_BIT(CPB)) dut (
    .clk (clk), .rst_n (rst_n),
    .bus_wr (bus_wr), .bus_rd (bus_rd), .bus_addr (bus_addr),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .rxd (rxd), .txd (txd),
    .rx_irq (rx_irq), .err_irq (err_irq), .dma_req (dma_req), .dma_ack (dma_ack)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic send_rx(input logic [8:0] v, input bit nine, input bit stp);
    rxd = 1'b0;
    repeat (CPB) @(negedge clk);
    for (int i = 0; i < (nine ? 9 : 8); i++) begin
      rxd = v[i];
      repeat (CPB) @(negedge clk);
    end
    rxd = stp;
    repeat (CPB) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * CPB) @(negedge clk);
  endtask

  task automatic cap_tx(input bit nine, output logic [8:0] dat, output logic stp);
    @(negedge clk);
    while (txd !== 1'b0) @(negedge clk);
    repeat (CPB / 2) @(negedge clk);
    dat = '0;
    for (int i = 0; i < (nine ? 9 : 8); i++) begin
      repeat (CPB) @(negedge clk);
      dat[i] = txd;
    end
    repeat (CPB) @(negedge clk);
    stp = txd;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    rxd = 1'b1; dma_ack = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Reset state
    rd(2'd1, rv);
    chk((rv & 8'h3F) == 8'h00, "R7 ctrl low bits", {8'h0, rv & 8'h3F}, 16'h0);
    rd(2'd2, rv);
    chk(rv == 8'h00, "R7 status", {8'h0, rv}, 16'h0);
    chk(txd == 1'b1, "R1 idle txd", {15'h0, txd}, 16'h1);
    chk(!rx_irq && !dma_req && !err_irq, "R7 outputs low",
        {13'h0, rx_irq, dma_req, err_irq}, 16'h0);

    // Transmit, 8-bit mode
    for (int i = 0; i < 6; i++) begin
      b8 = 8'(i * 53 + 17);
      fork
        cap_tx(1'b0, got, gstp);
        wr(2'd0, b8);
      join
      chk(got[7:0] == b8, "R1 tx 8-bit data", {8'h0, got[7:0]}, {8'h0, b8});
      chk(gstp == 1'b1, "R1 tx stop", {15'h0, gstp}, 16'h1);
      repeat (2 * CPB) @(negedge clk);
    end

    // Transmit, 9-bit mode
    wr(2'd2, 8'h01);
    for (int i = 0; i < 8; i++) begin
      b8 = 8'(i * 29 + 5);
      wr(2'd1, {1'b0, i[0], 6'h0});
      fork
        cap_tx(1'b1, got, gstp);
        wr(2'd0, b8);
      join
      chk(got == {i[0], b8}, "R2 tx 9-bit word", {7'h0, got}, {7'h0, i[0], b8});
      chk(gstp == 1'b1, "R1 tx 9-bit stop", {15'h0, gstp}, 16'h1);
      repeat (2 * CPB) @(negedge clk);
    end

    // Ninth bit bound to its byte despite a later rewrite
    wr(2'd1, 8'h40);
    fork
      cap_tx(1'b1, got, gstp);
      begin
        wr(2'd0, 8'hA5);
        wr(2'd1, 8'h00);
      end
    join
    chk(got == 9'h1A5, "R2 ninth bit atomic", {7'h0, got}, 16'h01A5);
    repeat (2 * CPB) @(negedge clk);
    fork
      cap_tx(1'b1, got, gstp);
      wr(2'd0, 8'h5A);
    join
    chk(got == 9'h05A, "R2 ninth bit after rewrite", {7'h0, got}, 16'h005A);
    repeat (2 * CPB) @(negedge clk);

    // Receive, 9-bit mode, CPU path
    for (int i = 0; i < 12; i++) begin
      v9 = {i[1], 8'(i * 71 + 3)};
      send_rx(v9, 1'b1, 1'b1);
      chk(rx_irq == 1'b1 && dma_req == 1'b0, "R9 cpu path",
          {14'h0, rx_irq, dma_req}, 16'h2);
      rd(2'd1, rv);
      chk(rv[7] == v9[8], "R3 R5 ninth bit", {15'h0, rv[7]}, {15'h0, v9[8]});
      rd(2'd0, rv);
      chk(rv == v9[7:0], "R3 rx byte", {8'h0, rv}, {8'h0, v9[7:0]});
      chk(rx_irq == 1'b0, "R10 read clears full", {15'h0, rx_irq}, 16'h0);
      r8_exp = v9[8];
    end

    // Captured ninth bit is read-only
    wr(2'd1, {~r8_exp, 7'h00});
    rd(2'd1, rv);
    chk(rv[7] == r8_exp, "R13 bit 7 read-only", {15'h0, rv[7]}, {15'h0, r8_exp});

    // Receive, 8-bit mode
    wr(2'd2, 8'h00);
    for (int i = 0; i < 8; i++) begin
      b8 = 8'(i * 97 + 11);
      send_rx({1'b0, b8}, 1'b0, 1'b1);
      rd(2'd1, rv);
      chk(rv[7] == b8[7], "R4 copy of bit 7", {15'h0, rv[7]}, {15'h0, b8[7]});
      rd(2'd0, rv);
      chk(rv == b8, "R4 rx 8-bit byte", {8'h0, rv}, {8'h0, b8});
    end

    // DMA path
    wr(2'd1, 8'h20);
    send_rx(9'h03C, 1'b0, 1'b1);
    chk(dma_req == 1'b1 && rx_irq == 1'b0, "R8 dma path",
        {14'h0, dma_req, rx_irq}, 16'h2);
    @(negedge clk); dma_ack = 1'b1;
    @(negedge clk); dma_ack = 1'b0;
    chk(dma_req == 1'b0, "R10 ack clears full", {15'h0, dma_req}, 16'h0);
    rd(2'd0, rv);
    chk(rv == 8'h3C, "R8 dma byte held", {8'h0, rv}, 16'h003C);

    // Overrun
    wr(2'd1, 8'h08);
    send_rx(9'h011, 1'b0, 1'b1);
    send_rx(9'h022, 1'b0, 1'b1);
    chk(err_irq == 1'b1, "R11 overrun irq", {15'h0, err_irq}, 16'h1);
    rd(2'd2, rv);
    chk(rv[2] == 1'b1, "R11 overrun flag", {15'h0, rv[2]}, 16'h1);
    chk(err_irq == 1'b0, "R11 status read clears", {15'h0, err_irq}, 16'h0);
    rd(2'd0, rv);
    chk(rv == 8'h11, "R11 old byte kept", {8'h0, rv}, 16'h0011);

    // Framing with interrupt enabled
    wr(2'd1, 8'h02);
    send_rx(9'h055, 1'b0, 1'b0);
    chk(err_irq == 1'b1, "R12 framing irq", {15'h0, err_irq}, 16'h1);
    rd(2'd2, rv);
    chk(rv[3] == 1'b1, "R12 framing flag", {15'h0, rv[3]}, 16'h1);
    chk(err_irq == 1'b0, "R12 status read clears", {15'h0, err_irq}, 16'h0);
    rd(2'd0, rv);

    // Framing with interrupt disabled
    wr(2'd1, 8'h00);
    send_rx(9'h066, 1'b0, 1'b0);
    chk(err_irq == 1'b0, "R12 masked irq", {15'h0, err_irq}, 16'h0);
    rd(2'd2, rv);
    chk(rv[3] == 1'b1, "R12 masked flag", {15'h0, rv[3]}, 16'h1);
    rd(2'd0, rv);

    // Reset keeps the ninth-bit holders
    wr(2'd2, 8'h01);
    wr(2'd1, 8'h6F);
    send_rx(9'h1AB, 1'b1, 1'b1);
    rd(2'd0, rv);
    rd(2'd1, rv);
    chk(rv == 8'hEF, "R6 ctrl before reset", {8'h0, rv}, 16'h00EF);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(2'd1, rv);
    chk(rv[7:6] == 2'b11, "R6 bits kept", {14'h0, rv[7:6]}, 16'h3);
    chk(rv[5:0] == 6'h00, "R7 enables cleared", {10'h0, rv[5:0]}, 16'h0);
    rd(2'd2, rv);
    chk(rv == 8'h00, "R7 mode cleared", {8'h0, rv}, 16'h0);

    finish_run();
  end
endmodule